// File: doc/BRIEF.md
# DC-Balanced Three-Lane Word Serializer

This block turns a 21-bit parallel word into three serial bit streams plus a forwarded clock stream. It runs on a bit-rate clock. A single-cycle word strobe, which arrives once every nine bit clocks, marks each word. The word is cut into three 7-bit groups, one per lane. Each lane keeps a signed running disparity, the count of ones sent minus the count of zeros sent. At the word boundary the lane decides whether to send its group inverted or as it is. The lane puts two complementary marker slots in front of the group, so a receiver can undo the inversion. The 9-slot symbol then leaves the lane serially, one slot per bit clock.

The forwarded clock stream is high for the first 4 slots of one word and the first 5 slots of the next, alternating, so over two words it carries as many ones as zeros. A mode input turns off balancing for plain transmission. A power-down input drops the output enable and returns all internal state to its reset condition.

Top module: `dcb_serializer`

## Requirements
- R1: Input bits 20..14 feed lane 2 (`ser_out[2]`), bits 13..7 feed lane 1 and bits 6..0 feed lane 0.
- R2: Each lane sends 9 slots per word, in this order: marker A, marker B, then data bits from the highest index to the lowest. A word captured on a strobe goes out starting at the next strobe. Its slot 0 is visible in the bit-clock cycle that follows that strobe edge.
- R3: In balanced mode the two markers are always complements of each other. A=1, B=0 means the group was sent inverted. A=0, B=1 means the group was sent unchanged.
- R4: In balanced mode a group is inverted exactly when the lane's running disparity is nonzero and the group's own disparity (ones minus zeros, always odd) has the same sign as it.
- R5: The running disparity is zero after reset. At each strobe it gains the disparity of the symbol actually sent. It never exceeds the group width (7) in magnitude.
- R6: The forwarded clock `ser_clk` is high in the first 4 slots of the first word after reset or power-down. It is high in the first 5 slots of the next word, and it keeps alternating 4 and 5 on every later strobe. The remaining slots are low.
- R7: A high `pwr_dn` sampled on a clock edge drives `out_en` low and `ser_out`, `ser_clk` to 0 from that edge on. It also clears the running disparities, the captured word and the clock phase. `out_en` rises on the first edge at which `pwr_dn` is low.
- R8: With `balance_en` low at a strobe, the group is sent unchanged with both markers 0. While `balance_en` is low the running disparity is held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_stb | input | 1 | One-cycle strobe, captures `par_in` and starts a new symbol |
| par_in | input | 21 | Parallel input word |
| balance_en | input | 1 | 1 selects balanced coding, 0 plain coding |
| pwr_dn | input | 1 | Power-down request |
| ser_out | output | 3 | Serial data, one bit per lane |
| ser_clk | output | 1 | Forwarded clock slot pattern |
| out_en | output | 1 | Output enable for the serial drivers |

## Verification
A fixed word sequence walks each lane's running disparity through both signs, zero and the limit of 7. This catches a wrong sign test or a missing zero check, because either one flips the marker pair and the inverted data of a later word. A power-down lands in the middle of a symbol while the running sums are negative. If the sums were not cleared, the first all-zero word afterwards would go out inverted. If the clock phase were not reset, that word would carry a 5-slot clock instead of 4. The plain-mode words check that the markers read 00 and that a disparity left over from plain mode cannot make the next balanced word go out inverted.

// File: rtl/dcb_pkg.sv
package dcb_pkg;

   // Marker slot pair {A, B} sent ahead of each data group
   typedef enum logic [1:0] {
      MARK_RAW  = 2'b00,
      MARK_KEEP = 2'b01,
      MARK_INV  = 2'b10
   } mark_e;

   // Forwarded clock phase: short high (floor(slots/2)) or long high
   typedef enum logic {
      PH_SHORT = 1'b0,
      PH_LONG  = 1'b1
   } clk_phase_e;

endpackage

// File: rtl/dcb_lane_enc.sv
module dcb_lane_enc
   import dcb_pkg::*;
#(
   parameter int GRP_W = 7,
   parameter int SUM_W = 5,
   localparam int SLOTS = GRP_W + 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             load,
   input  logic             balance,
   input  logic [GRP_W-1:0] grp_i,
   output logic [SLOTS-1:0] sym_o
);

   localparam int CNT_W = $clog2(GRP_W + 1);

   logic [CNT_W-1:0]        ones;
   logic signed [SUM_W-1:0] disp;
   logic signed [SUM_W-1:0] sent;
   logic signed [SUM_W-1:0] sum_q;
   logic                    inv;
   mark_e                   mark;

   // population count of the group
   always_comb begin
      ones = '0;
      for (int i = 0; i < GRP_W; i++) begin
         ones = ones + CNT_W'(grp_i[i]);
      end
   end

   // disparity = ones - zeros = 2*ones - width (odd, never zero)
   assign disp = $signed(SUM_W'({ones, 1'b0})) - $signed(SUM_W'(GRP_W));

   // invert when running sum is nonzero and pushes the same way
   assign inv  = balance && (sum_q != '0) && (disp[SUM_W-1] == sum_q[SUM_W-1]);
   assign sent = inv ? -disp : disp;

   always_comb begin
      if (!balance)  mark = MARK_RAW;
      else if (inv)  mark = MARK_INV;
      else           mark = MARK_KEEP;
   end

   assign sym_o = {mark, (inv ? ~grp_i : grp_i)};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 sum_q <= '0;
      else if (clr || !balance)   sum_q <= '0;
      else if (load)              sum_q <= sum_q + sent;
   end

   // R5: running disparity stays within one group width
   p_sum_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sum_q <= GRP_W) && (sum_q >= -GRP_W));

   // R5: every balanced load moves the sum (symbol disparity is odd)
   p_sum_moves_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (load && balance && !clr) |=> (sum_q != $past(sum_q)));

   // R8: plain mode pins the running sum at zero
   p_sum_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !balance |=> (sum_q == '0));

endmodule

// File: rtl/dcb_piso.sv
module dcb_piso #(
   parameter int W = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         load,
   input  logic [W-1:0] din,
   output logic         dout
);

   logic [W-1:0] sr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sr_q <= '0;
      else if (clr)   sr_q <= '0;
      else if (load)  sr_q <= din;
      else            sr_q <= {sr_q[W-2:0], 1'b0};
   end

   assign dout = sr_q[W-1];

   // R7: a clear silences the serial output on the next cycle
   p_clr_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !dout);

endmodule

// File: rtl/dcb_fwd_clk.sv
module dcb_fwd_clk
   import dcb_pkg::*;
#(
   parameter int SLOTS = 9
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic load,
   output logic clk_o
);

   localparam int HI_SHORT = SLOTS / 2;
   localparam int HI_LONG  = SLOTS - HI_SHORT;

   clk_phase_e       phase_q;
   logic [SLOTS-1:0] pat;

   always_comb begin
      int hi;
      hi  = (phase_q == PH_LONG) ? HI_LONG : HI_SHORT;
      pat = '0;
      for (int i = 0; i < SLOTS; i++) begin
         if (i < hi) pat[SLOTS-1-i] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     phase_q <= PH_SHORT;
      else if (clr)   phase_q <= PH_SHORT;
      else if (load)  phase_q <= (phase_q == PH_SHORT) ? PH_LONG : PH_SHORT;
   end

   dcb_piso #(.W(SLOTS)) u_clk_sh (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .load  (load),
      .din   (pat),
      .dout  (clk_o)
   );

   // R6: the high time alternates on every accepted word
   p_phase_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !clr) |=> (phase_q != $past(phase_q)));

endmodule

// File: rtl/dcb_serializer.sv
module dcb_serializer #(
   parameter int LANES = 3,
   parameter int GRP_W = 7,
   parameter int SUM_W = 5,
   localparam int DATA_W = LANES * GRP_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              word_stb,
   input  logic [DATA_W-1:0] par_in,
   input  logic              balance_en,
   input  logic              pwr_dn,
   output logic [LANES-1:0]  ser_out,
   output logic              ser_clk,
   output logic              out_en
);

   localparam int SLOTS = GRP_W + 2;

   // elaboration-time parameter checks
   if (LANES < 1) begin : g_chk_lanes
      $error("dcb_serializer: LANES must be at least 1");
   end
   if ((GRP_W % 2) == 0) begin : g_chk_odd
      $error("dcb_serializer: GRP_W must be odd so disparity is never zero");
   end
   if (((1 << (SUM_W - 1)) - 1) < GRP_W) begin : g_chk_sum
      $error("dcb_serializer: SUM_W too narrow for a sum of +/-GRP_W");
   end

   logic [DATA_W-1:0] pend_q;
   logic              bal_q;
   logic              out_en_q;
   logic              load;

   assign load = word_stb && !pwr_dn;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q   <= '0;
         bal_q    <= 1'b0;
         out_en_q <= 1'b0;
      end else begin
         out_en_q <= !pwr_dn;
         if (pwr_dn) begin
            pend_q <= '0;
         end else if (word_stb) begin
            pend_q <= par_in;
            bal_q  <= balance_en;
         end
      end
   end

   assign out_en = out_en_q;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [SLOTS-1:0] sym;

      dcb_lane_enc #(.GRP_W(GRP_W), .SUM_W(SUM_W)) u_enc (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr     (pwr_dn),
         .load    (load),
         .balance (balance_en),
         .grp_i   (pend_q[l*GRP_W +: GRP_W]),
         .sym_o   (sym)
      );

      dcb_piso #(.W(SLOTS)) u_sh (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (pwr_dn),
         .load  (load),
         .din   (sym),
         .dout  (ser_out[l])
      );
   end

   dcb_fwd_clk #(.SLOTS(SLOTS)) u_fclk (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (pwr_dn),
      .load  (load),
      .clk_o (ser_clk)
   );

   // R7: disabled outputs carry no activity
   p_off_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !out_en |-> ((ser_out == '0) && !ser_clk));

   // R7: power-down drops the enable on the following cycle
   p_en_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_dn |=> !out_en);

   // R3: in balanced mode marker B is the complement of marker A on every lane
   p_mark_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(word_stb, 2) && !$past(word_stb) && !$past(pwr_dn, 2) &&
       !$past(pwr_dn) && bal_q) |-> (ser_out == ~$past(ser_out)));

endmodule

// File: tb/dcb_serializer_bench.sv
`timescale 1ns/1ps
module dcb_serializer_bench;

   localparam int LN = 3;
   localparam int GW = 7;
   localparam int SL = GW + 2;
   localparam int DW = LN * GW;
   localparam int NVEC = 6;

   // {inversion flags of the word sent at this strobe (lane2..lane0), word captured}
   localparam logic [23:0] VEC [NVEC] = '{
      {3'b000, 7'h7F, 7'h00, 7'h01},
      {3'b011, 7'h0F, 7'h0F, 7'h03},
      {3'b001, 7'h70, 7'h7E, 7'h55},
      {3'b011, 7'h2A, 7'h01, 7'h7F},
      {3'b010, 7'h00, 7'h3F, 7'h7F},
      {3'b111, 7'h7F, 7'h1F, 7'h00}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          word_stb = 1'b0;
   logic [DW-1:0] par_in = '0;
   logic          balance_en = 1'b1;
   logic          pwr_dn = 1'b0;
   logic [LN-1:0] ser_out;
   logic          ser_clk;
   logic          out_en;

   int total = 0;
   int bad = 0;
   int stb_idx = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   dcb_serializer u_dcb_serializer (
      .clk        (clk),
      .rst_n      (rst_n),
      .word_stb   (word_stb),
      .par_in     (par_in),
      .balance_en (balance_en),
      .pwr_dn     (pwr_dn),
      .ser_out    (ser_out),
      .ser_clk    (ser_clk),
      .out_en     (out_en)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] got,
                      input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
      end
   endtask

   function automatic logic [SL-1:0] exp_sym(input logic [GW-1:0] g, input logic bal,
                                             input logic inv);
      if (!bal)     return {2'b00, g};
      else if (inv) return {2'b10, ~g};
      else          return {2'b01, g};
   endfunction

   function automatic logic [SL-1:0] exp_clk(input int idx);
      int hi;
      logic [SL-1:0] p;
      hi = (idx % 2 == 0) ? SL / 2 : SL - SL / 2;
      p = '0;
      for (int i = 0; i < SL; i++) if (i < hi) p[SL-1-i] = 1'b1;
      return p;
   endfunction

   // strobe a new word, then collect the 9 slots of the previous one
   task automatic xfer(input logic [DW-1:0] cap, input logic bal,
                       input logic [DW-1:0] tx, input logic [2:0] inv, input string tag);
      logic [SL-1:0] got_l [LN];
      logic [SL-1:0] got_c;
      logic [SL-1:0] ec;
      word_stb   = 1'b1;
      par_in     = cap;
      balance_en = bal;
      for (int s = 0; s < SL; s++) begin
         @(negedge clk);
         if (s == 0) word_stb = 1'b0;
         for (int l = 0; l < LN; l++) got_l[l][SL-1-s] = ser_out[l];
         got_c[SL-1-s] = ser_clk;
      end
      for (int l = 0; l < LN; l++) begin
         logic [SL-1:0] e;
         e = exp_sym(tx[l*GW +: GW], bal, inv[l]);
         chk(got_l[l] == e, $sformatf("%s lane%0d symbol", tag, l), 32'(got_l[l]), 32'(e));
      end
      ec = exp_clk(stb_idx);
      chk(got_c == ec, $sformatf("R6 forwarded clock strobe %0d", stb_idx), 32'(got_c), 32'(ec));
      stb_idx++;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // reset state
      chk(out_en == 1'b0, "R7 out_en in reset", 32'(out_en), 0);
      chk(ser_out == '0 && ser_clk == 1'b0, "R7 outputs idle in reset",
          32'({ser_out, ser_clk}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_en == 1'b1, "R7 out_en after reset", 32'(out_en), 1);

      // table walk: R1 R2 R3 R4 R5 under balanced coding
      for (int i = 0; i < NVEC; i++) begin
         logic [DW-1:0] tx;
         tx = (i == 0) ? '0 : VEC[i-1][DW-1:0];
         xfer(VEC[i][DW-1:0], 1'b1, tx, VEC[i][23:21], "R1/R2/R3/R4/R5");
      end

      // power-down in mid-symbol: last table word goes out, lane2 inverted
      word_stb   = 1'b1;
      par_in     = '0;
      balance_en = 1'b1;
      @(negedge clk);
      word_stb = 1'b0;
      chk(ser_out == 3'b100, "R3 marker A slot before power-down", 32'(ser_out), 32'h4);
      chk(ser_clk == 1'b1, "R6 clock slot0 high", 32'(ser_clk), 1);
      pwr_dn = 1'b1;
      @(negedge clk);
      chk(out_en == 1'b0, "R7 out_en dropped", 32'(out_en), 0);
      chk(ser_out == '0 && ser_clk == 1'b0, "R7 outputs silenced",
          32'({ser_out, ser_clk}), 0);
      repeat (2) @(negedge clk);
      chk(out_en == 1'b0, "R7 out_en held low", 32'(out_en), 0);
      pwr_dn = 1'b0;
      @(negedge clk);
      chk(out_en == 1'b1, "R7 out_en restored", 32'(out_en), 1);
      stb_idx = 0;

      // cleared word and cleared sums: zero word must not be inverted
      xfer('0, 1'b1, '0, 3'b000, "R5/R7 after power-down");
      // plain mode sends zero word with markers 00, no inversion
      xfer('0, 1'b0, '0, 3'b000, "R8 plain zero");
      // sum held at zero: zero word balanced next is unchanged
      xfer({7'h7F, 7'h00, 7'h2A}, 1'b1, '0, 3'b000, "R8 sum held");
      xfer({7'h55, 7'h55, 7'h55}, 1'b1, {7'h7F, 7'h00, 7'h2A}, 3'b011, "R4 sign rule");
      xfer('0, 1'b0, {7'h55, 7'h55, 7'h55}, 3'b000, "R8 plain data");

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule